// File: doc/BRIEF.md
# 8-bit Data-Transfer Instruction Executor

This block runs the move and load-immediate part of a classic 8-bit accumulator machine. It holds seven working byte registers, a 16-bit stack pointer and a program counter. It reads opcodes and operand bytes through one synchronous memory port, where read data appears one clock after the address. Memory operands are always reached indirectly through the address held in the H:L pair.

Each instruction keeps the legacy opcode bit pattern and the legacy count of machine cycles and clock states, and reports both when it finishes. Opcodes outside the move and load-immediate subset are not executed: they raise a flag and are skipped. The memory-to-memory move slot stops the machine. There is no condition-flag register, so no instruction here can alter a flag.

Top module: `dt_exec`

## Requirements
- R1: Opcode 01DDDSSS with neither field equal to 110 copies register SSS into register DDD, and reports 1 machine cycle and 5 states.
- R2: Opcode 01DDD110 (DDD not 110) loads register DDD from memory at address {H,L}, and reports 2 cycles and 7 states.
- R3: Opcode 01110SSS (SSS not 110) writes register SSS to memory at address {H,L}, and reports 2 cycles and 7 states. Every write drives mem_addr equal to {H,L}.
- R4: Opcode 00DDD110 with DDD not 110 loads the second instruction byte into register DDD, and reports 2 cycles and 7 states.
- R5: Opcode 00110110 writes the second instruction byte to memory at {H,L}, and reports 3 cycles and 10 states.
- R6: Opcode 00PP0001 loads the second byte into the low register and the third byte into the high register of pair PP, where 00=B:C, 01=D:E, 10=H:L and 11=stack pointer (low byte to sp[7:0], high byte to sp[15:8]). It reports 3 cycles and 10 states.
- R7: Register field codes are B=000, C=001, D=010, E=011, H=100, L=101, A=111. Code 110 selects memory at {H,L}.
- R8: When an instruction completes, pc has advanced past the instruction by its length: 1, 2 or 3 bytes.
- R9: Any other opcode, except 01110110, sets illegal for that completion. It writes nothing, advances pc by 1, and reports 1 cycle and 4 states.
- R10: Opcode 01110110 performs no move. It sets halted, advances pc by 1, and after that pc, sp and the registers hold, and mem_we stays low until reset.
- R11: While rst_n is low, pc and sp are 0, and done, illegal and halted are 0.
- R12: done is a one-clock pulse for each completed instruction other than the halt. last_mcycles, last_states and illegal describe that instruction and hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 8 | Read data, valid one clock after mem_addr |
| mem_addr | output | 16 | Memory address for a read or a write |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| done | output | 1 | Instruction-completed pulse |
| last_mcycles | output | 2 | Machine cycles of the last completed instruction |
| last_states | output | 4 | Clock states of the last completed instruction |
| illegal | output | 1 | Last completed opcode was outside the subset |
| halted | output | 1 | Halt slot executed, fetching stopped |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
The bench aims at the three opcodes that contain a 110 field. If the decoder treated the memory code as a register, a memory move would land in a phantom register and the stored bytes would come out wrong. The bench loads a pair with the low and high bytes in different orders, so a swapped byte order shows up in memory and on sp. It runs arithmetic opcodes that sit next to legal patterns, where a loose decode would write a register or skip the wrong number of bytes and misalign every later fetch. After the halt it watches pc and mem_we for a while, which catches a design that keeps fetching.

// File: rtl/dt_exec.sv
module dt_exec #(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        done,
  output logic [1:0]  last_mcycles,
  output logic [3:0]  last_states,
  output logic        illegal,
  output logic        halted,
  output logic [15:0] pc,
  output logic [15:0] sp
);
  localparam logic [2:0] MEMSEL = 3'b110;

  typedef enum logic [2:0] {FETCH, DEC, EX, RDM, B2, REQ3, B3, STOP} st_t;
  st_t st;

  logic [7:0] ir;
  logic [7:0] rf [0:7];

  wire [2:0] d  = ir[5:3];
  wire [2:0] s  = ir[2:0];
  wire [1:0] rp = ir[5:4];
  wire [15:0] hl = {rf[4], rf[5]};

  wire is_mov = ir[7:6] == 2'b01;
  wire is_hlt = ir == 8'h76;
  wire mov_rr = is_mov && d != MEMSEL && s != MEMSEL;
  wire mov_rm = is_mov && s == MEMSEL && d != MEMSEL;
  wire mov_mr = is_mov && d == MEMSEL && s != MEMSEL;
  wire is_mvi = ir[7:6] == 2'b00 && s == MEMSEL;
  wire mvi_m  = is_mvi && d == MEMSEL;
  wire is_lxi = ir[7:6] == 2'b00 && ir[3:0] == 4'b0001;
  wire is_bad = !(mov_rr || mov_rm || mov_mr || is_mvi || is_lxi || is_hlt);

  assign mem_we    = (st == EX && mov_mr) || (st == B2 && mvi_m);
  assign mem_addr  = ((st == EX && (mov_mr || mov_rm)) || (st == B2 && mvi_m)) ? hl : pc;
  assign mem_wdata = (st == B2) ? mem_rdata : rf[s];

  logic       fin, fin_bad;
  logic [1:0] fin_mc;
  logic [3:0] fin_st;

  always_comb begin
    fin = 1'b0; fin_bad = 1'b0; fin_mc = 2'd0; fin_st = 4'd0;
    case (st)
      EX: begin
        if (mov_rr)      begin fin = 1'b1; fin_mc = 2'd1; fin_st = 4'd5; end
        else if (mov_mr) begin fin = 1'b1; fin_mc = 2'd2; fin_st = 4'd7; end
        else if (is_bad) begin fin = 1'b1; fin_bad = 1'b1; fin_mc = 2'd1; fin_st = 4'd4; end
      end
      RDM: begin fin = 1'b1; fin_mc = 2'd2; fin_st = 4'd7; end
      B2: if (is_mvi) begin
        fin = 1'b1;
        fin_mc = mvi_m ? 2'd3 : 2'd2;
        fin_st = mvi_m ? 4'd10 : 4'd7;
      end
      B3: begin fin = 1'b1; fin_mc = 2'd3; fin_st = 4'd10; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FETCH; ir <= 8'h00; pc <= RESET_PC; sp <= 16'h0000;
      done <= 1'b0; illegal <= 1'b0; halted <= 1'b0;
      last_mcycles <= 2'd0; last_states <= 4'd0;
      for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
    end else begin
      done <= fin;
      if (fin) begin
        last_mcycles <= fin_mc; last_states <= fin_st; illegal <= fin_bad;
      end
      case (st)
        FETCH: st <= DEC;
        DEC: begin ir <= mem_rdata; pc <= pc + 16'd1; st <= EX; end
        EX: begin
          st <= FETCH;
          if (mov_rr) rf[d] <= rf[s];
          if (mov_rm) st <= RDM;
          if (is_mvi || is_lxi) st <= B2;
          if (is_hlt) begin halted <= 1'b1; st <= STOP; end
        end
        RDM: begin rf[d] <= mem_rdata; st <= FETCH; end
        B2: begin
          pc <= pc + 16'd1;
          st <= FETCH;
          if (is_mvi && !mvi_m) rf[d] <= mem_rdata;
          if (is_lxi) begin
            st <= REQ3;
            if (rp == 2'b11) sp[7:0] <= mem_rdata;
            else rf[{rp, 1'b1}] <= mem_rdata;
          end
        end
        REQ3: st <= B3;
        B3: begin
          pc <= pc + 16'd1;
          st <= FETCH;
          if (rp == 2'b11) sp[15:8] <= mem_rdata;
          else rf[{rp, 1'b0}] <= mem_rdata;
        end
        default: st <= STOP;
      endcase
    end
  end

  a_r3_write_at_hl: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr == {rf[4], rf[5]});
  a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we && $stable(pc) && $stable(sp));
  a_r9_illegal_timing: assert property (@(posedge clk) disable iff (!rst_n)
    done && illegal |-> last_mcycles == 2'd1 && last_states == 4'd4);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_legal_timing: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal |-> (last_mcycles == 2'd1 && last_states == 4'd5) ||
                         (last_mcycles == 2'd2 && last_states == 4'd7) ||
                         (last_mcycles == 2'd3 && last_states == 4'd10));
endmodule

// File: tb/sim_dt_exec.sv
module sim_dt_exec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] mem_rdata, mem_wdata;
  logic [15:0] mem_addr, pc, sp;
  logic mem_we, done, illegal, halted;
  logic [1:0] last_mcycles;
  logic [3:0] last_states;

  always #5 clk = ~clk;

  dt_exec u0 (.clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done), .last_mcycles(last_mcycles),
    .last_states(last_states), .illegal(illegal), .halted(halted), .pc(pc), .sp(sp));

  logic [7:0] mem [0:511];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[8:0]];
  end

  int checks = 0, errors = 0, cursor = 0;
  int q_mc[$], q_st[$], q_ill[$], q_pc[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input int n, input int mc, input int stc, input int ill);
    cursor += n;
    q_tag.push_back(tag); q_mc.push_back(mc); q_st.push_back(stc);
    q_ill.push_back(ill); q_pc.push_back(cursor);
  endtask
  task automatic i1(input logic [7:0] op, input string tag, input int mc, input int stc, input int ill);
    mem[cursor] = op; push(tag, 1, mc, stc, ill);
  endtask
  task automatic i2(input logic [7:0] op, input logic [7:0] b, input string tag);
    mem[cursor] = op; mem[cursor+1] = b;
    push(tag, 2, op == 8'h36 ? 3 : 2, op == 8'h36 ? 10 : 7, 0);
  endtask
  task automatic i3(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi, input string tag);
    mem[cursor] = op; mem[cursor+1] = lo; mem[cursor+2] = hi; push(tag, 3, 3, 10, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_mc.size() == 0) chk(0, "R12 unexpected done", 1, 0);
      else begin
        string t; int mc, stc, ill, p;
        t = q_tag.pop_front(); mc = q_mc.pop_front(); stc = q_st.pop_front();
        ill = q_ill.pop_front(); p = q_pc.pop_front();
        chk(last_mcycles == mc[1:0], {t, " mcycles"}, last_mcycles, mc);
        chk(last_states == stc[3:0], {t, " states"}, last_states, stc);
        chk(illegal == ill[0], {t, " illegal R9"}, illegal, ill);
        chk(pc == p[15:0], {t, " pc R8"}, pc, p);
      end
    end
  end

  int hpc;
  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    i3(8'h21, 8'h00, 8'h01, "R6 lxi hl");
    i2(8'h06, 8'h5A, "R4 mvi b");
    i1(8'h48, "R1 mov c,b", 1, 5, 0);
    i1(8'h71, "R3 mov m,c", 2, 7, 0);
    i2(8'h2E, 8'h01, "R4 mvi l");
    i2(8'h36, 8'hC3, "R5 mvi m");
    i1(8'h7E, "R2 mov a,m", 2, 7, 0);
    i2(8'h2E, 8'h02, "R4 mvi l");
    i1(8'h77, "R7 mov m,a", 2, 7, 0);
    i3(8'h31, 8'h34, 8'h12, "R6 lxi sp");
    i3(8'h11, 8'h78, 8'h56, "R6 lxi de");
    i1(8'h2C, "R9 op 2c", 1, 4, 1);
    i2(8'h2E, 8'h03, "R4 mvi l");
    i1(8'h72, "R7 mov m,d", 2, 7, 0);
    i1(8'h80, "R9 op 80", 1, 4, 1);
    i2(8'h2E, 8'h04, "R4 mvi l");
    i1(8'h73, "R7 mov m,e", 2, 7, 0);
    i1(8'h7F, "R1 mov a,a", 1, 5, 0);
    i2(8'h2E, 8'h05, "R4 mvi l");
    i1(8'h74, "R6 mov m,h", 2, 7, 0);
    mem[cursor] = 8'h76; cursor++;
    hpc = cursor;

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pc == 16'h0 && sp == 16'h0, "R11 reset pc/sp", pc, 0);
    chk(!done && !illegal && !halted, "R11 reset flags", {done, illegal, halted}, 0);
    rst_n = 1'b1;

    for (int c = 0; c < 3000 && !halted; c++) @(negedge clk);
    chk(halted, "R10 halted reached (watchdog)", halted, 1);
    chk(q_mc.size() == 0, "R12 all completions seen", q_mc.size(), 0);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      chk(pc == hpc[15:0] && !mem_we && !done, "R10 halt holds", pc, hpc);
    end
    chk(sp == 16'h1234, "R6 sp bytes", sp, 16'h1234);
    chk(mem[9'h100] == 8'h5A, "R3 store c", mem[9'h100], 8'h5A);
    chk(mem[9'h101] == 8'hC3, "R5 store imm", mem[9'h101], 8'hC3);
    chk(mem[9'h102] == 8'hC3, "R2 load a", mem[9'h102], 8'hC3);
    chk(mem[9'h103] == 8'h56, "R6 d high", mem[9'h103], 8'h56);
    chk(mem[9'h104] == 8'h78, "R6 e low", mem[9'h104], 8'h78);
    chk(mem[9'h105] == 8'h01, "R6 h high", mem[9'h105], 8'h01);
    chk(mem[9'h106] == 8'h00, "R9 no stray write", mem[9'h106], 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule